// File: doc/BRIEF.md
# Return Address Stack Predictor

This block sits in the instruction fetch unit and supplies a guessed target for subroutine returns, so fetch can run past a return without waiting for the register file. Decode hands it three strobes: a call was seen, a return through the link register was seen, or a jump through some other register was seen. On a call the block computes the return address, which is the call PC plus 8 so that the delay slot is skipped. It records that address on a small circular stack. On a return it takes the most recent address off the stack and offers it as the predicted target on the next cycle.

A jump through any register other than the link register cannot be guessed. The block raises a fetch-stall request and holds it until the execution pipeline reports that the real target has been resolved. When calls nest deeper than the stack, the oldest record is overwritten without any fault. The outermost returns are then simply predicted wrong. Fixing the stack after a mispredict is left to other logic.

Top module: `ras_predictor`

## Requirements
- R1: A call strobe stores call_pc + 8 as the new top of the stack. A return strobe in a later cycle, with no stack activity in between, yields exactly that address.
- R2: A return strobe on a non-empty stack produces, one cycle later, ret_pred_vld = 1 and ret_pred_target equal to the top entry. The top then moves back to the previous entry, so returns replay calls in last-in first-out order.
- R3: The stack holds DEPTH = 8 entries. A call made when 8 entries are already live overwrites the oldest one without stalling, and the live count stays at 8. After 9 calls followed by 8 returns, the returns yield the last 8 addresses, newest first.
- R4: A strobe for a jump through another register raises fetch_stall one cycle later, with no prediction and no change to the stack.
- R5: fetch_stall stays high, however many cycles pass, until a cycle with target_resolved. It is low one cycle after that strobe. A target_resolved strobe while no stall is pending has no effect.
- R6: A return strobe on an empty stack gives ret_pred_vld = 0 and ret_pred_target = the stale entry at the top pointer. The pointer does not move.
- R7: When several strobes coincide, a call wins over a return, and a return wins over the other-register jump. The losing strobes have no effect. When a jump strobe and target_resolved coincide, the stall is set.
- R8: ret_pred_vld is a single-cycle pulse. It is low in every cycle that does not follow an accepted return strobe. ret_pred_target keeps its last value between returns.
- R9: After synchronous reset the stack is empty, every entry holds zero, the top pointer is at entry 0, and ret_pred_vld, ret_pred_target and fetch_stall are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_vld | input | 1 | A call instruction was decoded this cycle |
| call_pc | input | 32 | PC of that call instruction |
| ret_vld | input | 1 | A jump through the link register was decoded this cycle |
| ijmp_vld | input | 1 | A jump through any other register was decoded this cycle |
| target_resolved | input | 1 | The pending indirect target has been computed |
| ret_pred_vld | output | 1 | The predicted return target is valid this cycle |
| ret_pred_target | output | 32 | Predicted return target |
| fetch_stall | output | 1 | Request to hold instruction fetch |

## Verification
Directed runs of nine calls followed by ten returns check three things: the last-in first-out order, the overwrite of the oldest entry, and the stale unflagged result from the empty stack. Together they separate a correct wrap from a stack that saturates or faults. Coinciding strobes are applied in every pairing to pin down the priority order. A long unresolved jump shows that the stall ends only on the resolve strobe and not after a fixed delay. A seeded random mix of calls, returns, jumps and resolves then drives the stack through repeated fill and drain cycles, and each result is compared against a reference stack kept in the bench.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // Operation chosen for one cycle after priority among the strobes
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_HALT = 2'd3
    } ras_op_e;

    // Distance from a call to its return point: call plus delay slot
    localparam int unsigned LINK_OFFSET = 8;

    // Priority: call, then link-register return, then other indirect jump
    function automatic ras_op_e pick_op(input logic call_s, input logic ret_s,
                                        input logic ijmp_s);
        if (call_s)      return OP_PUSH;
        else if (ret_s)  return OP_POP;
        else if (ijmp_s) return OP_HALT;
        else             return OP_IDLE;
    endfunction

    // Ring pointer helpers for a buffer of n slots
    function automatic int unsigned ring_inc(input int unsigned p, input int unsigned n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

    function automatic int unsigned ring_dec(input int unsigned p, input int unsigned n);
        return (p == 0) ? n - 1 : p - 1;
    endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  ras_op_e          op,
    output logic [PTR_W-1:0] top_ptr,
    output logic [PTR_W-1:0] push_ptr,
    output logic             live
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] fill;
    logic [PTR_W-1:0] prev_ptr;

    assign push_ptr = PTR_W'(ring_inc(32'(top_ptr), DEPTH));
    assign prev_ptr = PTR_W'(ring_dec(32'(top_ptr), DEPTH));
    assign live     = (fill != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            top_ptr <= '0;
            fill    <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    top_ptr <= push_ptr;
                    if (fill != FULL) fill <= fill + 1'b1;
                end
                OP_POP: begin
                    if (live) begin
                        top_ptr <= prev_ptr;
                        fill    <= fill - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL);

    p_full_stays_full_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH && fill == FULL) |=> (fill == FULL));

    p_empty_pop_still_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_POP && fill == '0) |=> (top_ptr == $past(top_ptr) && fill == '0));

    p_push_advances_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) |=> (top_ptr == $past(push_ptr)));

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_slot,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_slot,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (wr_en && wr_slot == PTR_W'(g))
                slot_q[g] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_slot];

endmodule

// File: rtl/ras_stall_ctrl.sv
module ras_stall_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic halt_req,
    input  logic resolved,
    output logic stall
);

    always_ff @(posedge clk) begin
        if (rst)           stall <= 1'b0;
        else if (halt_req) stall <= 1'b1;
        else if (resolved) stall <= 1'b0;
    end

    p_stall_rise_r4: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> stall);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (stall && !resolved) |=> stall);

    p_stall_release_r5: assert property (@(posedge clk) disable iff (rst)
        (resolved && !halt_req) |=> !stall);

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_vld,
    input  logic [ADDR_W-1:0] call_pc,
    input  logic              ret_vld,
    input  logic              ijmp_vld,
    input  logic              target_resolved,
    output logic              ret_pred_vld,
    output logic [ADDR_W-1:0] ret_pred_target,
    output logic              fetch_stall
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ras_op_e           op;
    logic [PTR_W-1:0]  top_ptr;
    logic [PTR_W-1:0]  push_ptr;
    logic              live;
    logic [ADDR_W-1:0] link_addr;
    logic [ADDR_W-1:0] top_data;

    assign op        = pick_op(call_vld, ret_vld, ijmp_vld);
    assign link_addr = call_pc + ADDR_W'(LINK_OFFSET);

    ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .top_ptr  (top_ptr),
        .push_ptr (push_ptr),
        .live     (live)
    );

    ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (op == OP_PUSH),
        .wr_slot (push_ptr),
        .wr_data (link_addr),
        .rd_slot (top_ptr),
        .rd_data (top_data)
    );

    ras_stall_ctrl u_stall (
        .clk      (clk),
        .rst      (rst),
        .halt_req (op == OP_HALT),
        .resolved (target_resolved),
        .stall    (fetch_stall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_pred_vld    <= 1'b0;
            ret_pred_target <= '0;
        end else begin
            ret_pred_vld <= (op == OP_POP) && live;
            if (op == OP_POP) ret_pred_target <= top_data;
        end
    end

    p_push_lands_on_top_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) |=> (top_data == $past(link_addr)));

    p_push_then_pop_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) ##1 (op == OP_POP) |=>
            (ret_pred_vld && ret_pred_target == $past(link_addr, 2)));

    p_call_beats_ret_r7: assert property (@(posedge clk) disable iff (rst)
        (call_vld && ret_vld) |=> !ret_pred_vld);

    p_call_blocks_halt_r7: assert property (@(posedge clk) disable iff (rst)
        (call_vld && ijmp_vld && !fetch_stall) |=> !fetch_stall);

    p_pulse_only_r8: assert property (@(posedge clk) disable iff (rst)
        !ret_vld |=> !ret_pred_vld);

    p_empty_no_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (ret_vld && !call_vld && !live) |=> !ret_pred_vld);

endmodule

// File: tb/ras_predictor_test.sv
`timescale 1ns/1ps
module ras_predictor_test;

    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        call_vld, ret_vld, ijmp_vld, target_resolved;
    logic [31:0] call_pc;
    logic        ret_pred_vld, fetch_stall;
    logic [31:0] ret_pred_target;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    // reference stack
    logic [31:0] m_mem [D];
    int          m_tos, m_cnt;
    bit          m_stall;

    always #2.5 clk = ~clk;

    ras_predictor uut (
        .clk(clk), .rst(rst), .call_vld(call_vld), .call_pc(call_pc),
        .ret_vld(ret_vld), .ijmp_vld(ijmp_vld), .target_resolved(target_resolved),
        .ret_pred_vld(ret_pred_vld), .ret_pred_target(ret_pred_target),
        .fetch_stall(fetch_stall)
    );

    function automatic logic [31:0] link_of(input logic [31:0] pc);
        return pc + 32'd8;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    endtask

    // Drive one cycle (caller is just after a falling edge), check one cycle later
    task automatic step(input bit c, input logic [31:0] pc, input bit r, input bit j,
                        input bit res, input string req);
        bit          exp_vld = 0;
        bit          chk_tgt = 0;
        logic [31:0] exp_tgt = '0;
        call_vld = c; call_pc = pc; ret_vld = r; ijmp_vld = j; target_resolved = res;
        if (c) begin
            m_tos = (m_tos + 1) % D;
            m_mem[m_tos] = link_of(pc);
            if (m_cnt < D) m_cnt++;
        end else if (r) begin
            chk_tgt = 1;
            exp_tgt = m_mem[m_tos];
            exp_vld = (m_cnt > 0);
            if (m_cnt > 0) begin
                m_tos = (m_tos + D - 1) % D;
                m_cnt--;
            end
        end else if (j) begin
            m_stall = 1;
        end
        if (!(j && !c && !r) && res) m_stall = 0;
        @(posedge clk);
        @(negedge clk);
        call_vld = 0; ret_vld = 0; ijmp_vld = 0; target_resolved = 0;
        check(ret_pred_vld == exp_vld, {req, " pred_vld"}, 32'(ret_pred_vld), 32'(exp_vld));
        if (chk_tgt)
            check(ret_pred_target == exp_tgt, {req, " pred_target"}, ret_pred_target, exp_tgt);
        check(fetch_stall == m_stall, {req, " stall"}, 32'(fetch_stall), 32'(m_stall));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_miss++;
            n_vec++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        call_vld = 0; ret_vld = 0; ijmp_vld = 0; target_resolved = 0; call_pc = '0;
        rst = 1;
        for (int i = 0; i < D; i++) m_mem[i] = '0;
        m_tos = 0; m_cnt = 0; m_stall = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R9: reset state
        check(ret_pred_vld == 1'b0, "R9 pred_vld", 32'(ret_pred_vld), 0);
        check(ret_pred_target == '0, "R9 pred_target", ret_pred_target, 0);
        check(fetch_stall == 1'b0, "R9 stall", 32'(fetch_stall), 0);

        // R6: return on an empty stack after reset: stale zero, not valid
        step(0, 0, 1, 0, 0, "R6");

        // R1/R2: single call then return
        step(1, 32'h0000_4000, 0, 0, 0, "R1");
        step(0, 0, 1, 0, 0, "R1");

        // R3: nine calls overflow, then ten returns (LIFO, oldest lost, empty tail)
        for (int i = 0; i < 9; i++) step(1, 32'h0001_0000 + 32'(i) * 32'h40, 0, 0, 0, "R3");
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 0, "R3");
        step(0, 0, 1, 0, 0, "R6");
        step(0, 0, 1, 0, 0, "R6");

        // R2: nested order with idle gaps
        step(1, 32'h0000_0100, 0, 0, 0, "R2");
        step(1, 32'h0000_0200, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 1, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 1, 0, 0, "R2");

        // R4/R5: long unresolved jump, then release, then spare resolve
        step(0, 0, 0, 1, 0, "R4");
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 1, "R5");

        // R7: coinciding strobes
        step(1, 32'h0000_0A00, 1, 0, 0, "R7");
        step(1, 32'h0000_0B00, 0, 1, 0, "R7");
        step(0, 0, 1, 1, 0, "R7");
        step(0, 0, 0, 1, 1, "R7");
        step(0, 0, 0, 0, 1, "R5");
        step(0, 0, 1, 0, 0, "R7");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned k = $urandom % 100;
            bit c = (k < 30);
            bit r = (k >= 25 && k < 60);
            bit j = (k >= 58 && k < 66);
            bit s = (($urandom % 100) < 12);
            step(c, $urandom & 32'hFFFF_FFFC, r, j, s, "R2");
        end

        finish_run();
    end

endmodule